// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a memory-mapped watchdog timer. A free-running count register climbs upward on a slow tick. The tick arrives as a one-cycle enable pulse in the bus clock domain, and an optional power-of-two prescaler can divide it further. Software keeps the system alive by writing the trigger register with a value that differs from the last trigger value it wrote. A common habit is to alternate a pattern with its complement. Each such write reloads the count from the load register. If software stops doing this, the count passes its all-ones value and the block raises `wdog_rst` for one clock and reloads. The reset controller downstream takes that pulse.

Every register write is posted. The written word waits in a shadow register, and the register's bit in the pending status register stays set for a fixed number of ticks. The new value takes effect in the cycle the bit clears. Writes that arrive while a register is still pending are dropped. The timer runs or halts only after a two-word key sequence reaches the key register through that same posted path. A small state machine checks the sequence:
- States: `KS_IDLE`, `KS_ARM_ON` (start word 1 seen) and `KS_ARM_OFF` (stop word 1 seen).
- Transitions from `KS_IDLE`: `go_arm_on` on 0xBBBB and `go_arm_off` on 0xAAAA.
- Transitions back to `KS_IDLE`: `start_done` on 0x4444 from `KS_ARM_ON`, `stop_done` on 0x5555 from `KS_ARM_OFF`, and `abort` on any other word from either arm state.
- Any other word in `KS_IDLE` leaves it there.

Top module: `kwd_top`

## Requirements
- R1: After reset the count reads 0, the timer is halted, the pending status reads 0, the control and load registers read 0, and the revision register (word address 0) returns the REV parameter in bits 7:0 with zeros above.
- R2: Word addresses are: revision 0, control 1, count 2, load 3, trigger 4, key 5, pending status 6. A write to control, load, trigger or key sets the register's pending bit from the next cycle: bit 0 for control, bit 2 for load, bit 3 for trigger, bit 4 for key. The bit clears on the PEND_TICKS-th tick after the write, and the new value takes effect on that same edge, not before.
- R3: A write to a register whose pending bit is set is ignored, and the value posted first is the one applied.
- R4: An applied key word 0xBBBB followed by an applied key word 0x4444 starts the timer. The count first advances on the tick after the one that applied 0x4444.
- R5: An applied 0xAAAA followed by an applied 0x5555 halts the timer. The tick that applies 0x5555 still advances the count, and later ticks do not.
- R6: If the second key word is not the partner of the first, the sequence aborts and the run state is unchanged.
- R7: An applied trigger value different from the previously applied trigger value reloads the count from the load register, running or not. An equal value does nothing. The previous trigger value is 0 after reset. A reload has priority over a count step on the same edge.
- R8: While halted, the count holds its value across ticks.
- R9: Control bit 5 enables the prescaler and bits 4:2 hold p. With the prescaler enabled, the running count advances once every 2^p ticks, the first step coming on the 2^p-th tick after start. With it disabled, the count advances on every tick.
- R10: A step from all ones reloads the count from the load register and drives `wdog_rst` high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle slow-domain tick enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench keeps the default 32-bit count and PEND_TICKS of 3, and sets REV to 0x5C. It drives the tick by hand, so every count value can be predicted to the tick, including the steps taken while key and trigger writes are still pending. Overflow comes within reach by loading 0xFFFFFFFC and reloading. Wraps can then be seen within a few ticks, both without the prescaler and with it at a divide of four.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int N_POSTED = 4;

    localparam logic [ADDR_W-1:0] A_REV  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LOAD = 3'd3;
    localparam logic [ADDR_W-1:0] A_TRIG = 3'd4;
    localparam logic [ADDR_W-1:0] A_KEY  = 3'd5;
    localparam logic [ADDR_W-1:0] A_PEND = 3'd6;

    localparam logic [15:0] KEY_ON_1  = 16'hBBBB;
    localparam logic [15:0] KEY_ON_2  = 16'h4444;
    localparam logic [15:0] KEY_OFF_1 = 16'hAAAA;
    localparam logic [15:0] KEY_OFF_2 = 16'h5555;

    localparam int CTRL_PRE_EN_BIT = 5;
    localparam int CTRL_PTV_LSB    = 2;
    localparam int PTV_W           = 3;

    typedef enum logic [1:0] {
        KS_IDLE    = 2'd0,
        KS_ARM_ON  = 2'd1,
        KS_ARM_OFF = 2'd2
    } key_state_e;

    // Posted slot index -> bus address
    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        case (idx)
            0:       slot_addr = A_CTRL;
            1:       slot_addr = A_LOAD;
            2:       slot_addr = A_TRIG;
            default: slot_addr = A_KEY;
        endcase
    endfunction

    // Posted slot index -> bit in pending status word
    function automatic int slot_pend_bit(input int idx);
        case (idx)
            0:       slot_pend_bit = 0;
            1:       slot_pend_bit = 2;
            2:       slot_pend_bit = 3;
            default: slot_pend_bit = 4;
        endcase
    endfunction

endpackage

// File: rtl/kwd_posted.sv
module kwd_posted #(
    parameter int DW         = 32,
    parameter int PEND_TICKS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          pend_o,
    output logic          apply_o,
    output logic [DW-1:0] data_o
);
    localparam int CW = (PEND_TICKS > 1) ? $clog2(PEND_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PEND_TICKS - 1);

    logic          pend_q;
    logic [CW-1:0] tcnt_q;
    logic [DW-1:0] data_q;
    logic          done;

    assign done    = pend_q && tick_i && (tcnt_q == LAST);
    assign pend_o  = pend_q;
    assign apply_o = done;
    assign data_o  = data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            tcnt_q <= '0;
            data_q <= '0;
        end else if (!pend_q) begin
            if (wr_i) begin
                pend_q <= 1'b1;
                tcnt_q <= '0;
                data_q <= wdata_i;
            end
        end else if (tick_i) begin
            if (done) begin
                pend_q <= 1'b0;
                tcnt_q <= '0;
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    AST_PEND_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !pend_q) |=> pend_q); // R2
    AST_CLEAR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(tick_i)); // R2
    AST_DROP_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && pend_q) |=> $stable(data_q)); // R3

endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_vld_i,
    input  logic [15:0] key_i,
    output logic        run_o
);
    key_state_e state_q, state_d;
    logic       run_q, run_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
            run_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // Next state and run output
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (key_vld_i) begin
            unique case (state_q)
                KS_IDLE: begin
                    if (key_i == KEY_ON_1)       state_d = KS_ARM_ON;   // go_arm_on
                    else if (key_i == KEY_OFF_1) state_d = KS_ARM_OFF;  // go_arm_off
                    else                         state_d = KS_IDLE;
                end
                KS_ARM_ON: begin
                    state_d = KS_IDLE;
                    if (key_i == KEY_ON_2) run_d = 1'b1;                // start_done
                end
                KS_ARM_OFF: begin
                    state_d = KS_IDLE;
                    if (key_i == KEY_OFF_2) run_d = 1'b0;               // stop_done
                end
                default: state_d = KS_IDLE;
            endcase
        end
    end

    assign run_o = run_q;

    AST_RUN_ONLY_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        !key_vld_i |=> $stable(run_q)); // R4
    AST_ARM_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (key_vld_i && state_q != KS_IDLE) |=> state_q == KS_IDLE); // R6

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W = 32,
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             pre_en_i,
    input  logic [PTV_W-1:0] ptv_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam int DIV_W = (1 << PTV_W) - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap_q;
    logic             step;
    logic             at_max;

    assign div_lim = DIV_W'((1 << ptv_i) - 1);
    assign step    = run_i && tick_i && (!pre_en_i || div_q == div_lim);
    assign at_max  = (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run_i || !pre_en_i) begin
            div_q <= '0;
        end else if (tick_i) begin
            div_q <= (div_q == div_lim) ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (reload_i) begin
                cnt_q <= load_i;
            end else if (step) begin
                if (at_max) begin
                    cnt_q  <= load_i;
                    wrap_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = wrap_q;

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !reload_i) |=> $stable(cnt_q)); // R8
    AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> cnt_q == $past(load_i)); // R10
    AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !pre_en_i && !reload_i && !at_max)
            |=> cnt_q == $past(cnt_q) + 1'b1); // R9

endmodule

// File: rtl/kwd_top.sv
module kwd_top
    import kwd_pkg::*;
#(
    parameter int          PEND_TICKS = 3,
    parameter logic [7:0]  REV        = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wdog_rst
);
    localparam int S_CTRL = 0;
    localparam int S_LOAD = 1;
    localparam int S_TRIG = 2;
    localparam int S_KEY  = 3;

    logic [N_POSTED-1:0]             pend;
    logic [N_POSTED-1:0]             apply;
    logic [N_POSTED-1:0][DATA_W-1:0] shadow;
    logic [DATA_W-1:0]               pend_word;

    logic [DATA_W-1:0] ctrl_q, load_q, trig_last_q, cnt;
    logic              run, reload;

    // One posted-write slot per writable register
    for (genvar i = 0; i < N_POSTED; i++) begin : g_slot
        kwd_posted #(.DW(DATA_W), .PEND_TICKS(PEND_TICKS)) u_posted (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .wr_i    (wr_en && (addr == slot_addr(i))),
            .wdata_i (wdata),
            .pend_o  (pend[i]),
            .apply_o (apply[i]),
            .data_o  (shadow[i])
        );
    end

    always_comb begin
        pend_word = '0;
        for (int i = 0; i < N_POSTED; i++) begin
            pend_word[slot_pend_bit(i)] = pend[i];
        end
    end

    // Applied register values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            load_q      <= '0;
            trig_last_q <= '0;
        end else begin
            if (apply[S_CTRL]) ctrl_q      <= shadow[S_CTRL];
            if (apply[S_LOAD]) load_q      <= shadow[S_LOAD];
            if (apply[S_TRIG]) trig_last_q <= shadow[S_TRIG];
        end
    end

    assign reload = apply[S_TRIG] && (shadow[S_TRIG] != trig_last_q);

    kwd_keyseq u_keyseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_vld_i (apply[S_KEY]),
        .key_i     (shadow[S_KEY][15:0]),
        .run_o     (run)
    );

    kwd_counter #(.CNT_W(DATA_W), .PTV_W(PTV_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .run_i    (run),
        .pre_en_i (ctrl_q[CTRL_PRE_EN_BIT]),
        .ptv_i    (ctrl_q[CTRL_PTV_LSB +: PTV_W]),
        .reload_i (reload),
        .load_i   (load_q),
        .cnt_o    (cnt),
        .wrap_o   (wdog_rst)
    );

    always_comb begin
        unique case (addr)
            A_REV:   rdata = {{(DATA_W-8){1'b0}}, REV};
            A_CTRL:  rdata = ctrl_q;
            A_CNT:   rdata = cnt;
            A_LOAD:  rdata = load_q;
            A_TRIG:  rdata = trig_last_q;
            A_KEY:   rdata = shadow[S_KEY];
            A_PEND:  rdata = pend_word;
            default: rdata = '0;
        endcase
    end

    AST_LOAD_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !apply[S_LOAD] |=> $stable(load_q)); // R2
    AST_PULSE_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> $past(run)); // R10

endmodule

// File: tb/kwd_top_bench.sv
module kwd_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] REV_T = 8'h5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wdog_rst;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    kwd_top #(.PEND_TICKS(3), .REV(REV_T)) u_kwd_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wdog_rst(wdog_rst)
    );

    always @(negedge clk) if (rst_n && wdog_rst) pulses++;

    // Monitor: pops expected items and compares against the read port
    always @(posedge clk) begin
        if (sbq.size() > 0) begin
            #(CLK_PERIOD/4);
            begin
                item_t it;
                it = sbq.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, addr, rdata, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = a;
        it.exp = e;
        it.tag = tag;
        sbq.push_back(it);
        wait (sbq.size() == 0);
    endtask

    task automatic expect_val(input int act, input int e, input string tag);
        checks++;
        if (act != e) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, e);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic post(input logic [2:0] a, input logic [31:0] d);
        wr(a, d);
        ticks(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_rd(3'd0, {24'h0, REV_T}, "R1 rev");
        expect_rd(3'd2, 32'h0, "R1 count");
        expect_rd(3'd6, 32'h0, "R1 pend");
        expect_rd(3'd3, 32'h0, "R1 load");
        // R2 posted load, R3 second write dropped
        wr(3'd3, 32'h100);
        expect_rd(3'd6, 32'h4, "R2 load pending bit2");
        wr(3'd3, 32'h999);
        ticks(2);
        expect_rd(3'd3, 32'h0, "R2 load not yet applied");
        ticks(1);
        expect_rd(3'd6, 32'h0, "R2 pend cleared");
        expect_rd(3'd3, 32'h100, "R3 first posted value kept");
        // R7 reload while halted, R8 hold
        wr(3'd4, 32'h1234);
        expect_rd(3'd6, 32'h8, "R2 trig pending bit3");
        ticks(3);
        expect_rd(3'd2, 32'h100, "R7 reload on new trigger");
        ticks(5);
        expect_rd(3'd2, 32'h100, "R8 halted count holds");
        // R4 start
        wr(3'd5, 32'hBBBB);
        expect_rd(3'd6, 32'h10, "R2 key pending bit4");
        ticks(3);
        post(3'd5, 32'h4444);
        expect_rd(3'd2, 32'h100, "R4 no step on start tick");
        ticks(4);
        expect_rd(3'd2, 32'h104, "R4 running");
        // R7 same value no reload, new value reload wins over step
        post(3'd4, 32'h1234);
        expect_rd(3'd2, 32'h107, "R7 equal trigger ignored");
        post(3'd4, 32'hEDCB);
        expect_rd(3'd2, 32'h100, "R7 reload beats step");
        // R6 abort
        post(3'd5, 32'hAAAA);
        post(3'd5, 32'h1234);
        ticks(2);
        expect_rd(3'd2, 32'h108, "R6 abort keeps running");
        // R5 stop
        post(3'd5, 32'hAAAA);
        post(3'd5, 32'h5555);
        expect_rd(3'd2, 32'h10E, "R5 stop tick still steps");
        ticks(3);
        expect_rd(3'd2, 32'h10E, "R5 halted");
        // R6 wrong partner on start
        post(3'd5, 32'hBBBB);
        post(3'd5, 32'h5555);
        ticks(3);
        expect_rd(3'd2, 32'h10E, "R6 mismatched start ignored");
        // R10 overflow without prescaler
        post(3'd3, 32'hFFFF_FFFC);
        post(3'd4, 32'h1234);
        expect_rd(3'd2, 32'hFFFF_FFFC, "R7 reload near max");
        post(3'd5, 32'hBBBB);
        post(3'd5, 32'h4444);
        ticks(3);
        expect_rd(3'd2, 32'hFFFF_FFFF, "R10 at max");
        expect_val(pulses, 0, "R10 no pulse before wrap");
        ticks(1);
        expect_rd(3'd2, 32'hFFFF_FFFC, "R10 wrap reloads");
        expect_val(pulses, 1, "R10 single-cycle pulse");
        post(3'd5, 32'hAAAA);
        post(3'd5, 32'h5555);
        expect_rd(3'd2, 32'hFFFF_FFFE, "R5 stop after wrap");
        expect_val(pulses, 2, "R10 second pulse");
        // R9 prescaler divide by 4
        wr(3'd1, 32'h28);
        expect_rd(3'd6, 32'h1, "R2 ctrl pending bit0");
        ticks(3);
        expect_rd(3'd1, 32'h28, "R9 ctrl applied");
        post(3'd5, 32'hBBBB);
        post(3'd5, 32'h4444);
        ticks(3);
        expect_rd(3'd2, 32'hFFFF_FFFE, "R9 no step before 4 ticks");
        ticks(1);
        expect_rd(3'd2, 32'hFFFF_FFFF, "R9 step on 4th tick");
        ticks(4);
        expect_rd(3'd2, 32'hFFFF_FFFC, "R9 R10 prescaled wrap");
        expect_val(pulses, 3, "R10 prescaled pulse");
        finish_run();
    end

endmodule